// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer Pair

Two 8-bit up-counting timer channels sit side by side and share one register port. Each channel picks its count source from a prescaled system clock or a synchronised external clock line. It compares its count against two registers and may clear itself on either match or on an external reset line. It drives one output pin whose level is set, cleared or toggled by each match, so pulse and PWM waveforms of any duty cycle can be built. Each channel keeps three sticky event flags: match A, match B and overflow. Each flag raises an interrupt line when its enable bit is set.

The channels can be joined in two ways. In wide mode they act as one 16-bit counter with channel 0 as the high byte. In event mode channel 1 counts the match A events of channel 0. Match A of channel 0 can also send a one-cycle strobe that starts an analog-to-digital conversion. The prescaler advances only on cycles where the clock-enable input is high.

Top module: `tmr_pair`

## Requirements
- R1: Clock select (ctrl bits [2:0]) 1, 2 and 3 advance the counter once every 8, 64 and 8192 cycles in which clk_en_i is high. Code 0 stops the counter. The prescaler does not move while clk_en_i is low.
- R2: Codes 4, 5 and 6 count rising, falling or both edges of the channel's ext_clk_i line after a two-flop synchroniser.
- R3: Clear select (ctrl bits [4:3]) 1 or 2 loads zero on the count tick at which the counter equals compare A or compare B, which gives a period of compare value plus one. Code 0 lets the counter run free and wrap from 0xFF to 0x00.
- R4: Clear select 3 holds the counter at zero while the channel's synchronised ext_rst_i line is high. Counting resumes after the line drops.
- R5: Action fields in the status register (bits [1:0] for match A, bits [3:2] for match B) set the pin action: 0 keep, 1 low, 2 high, 3 toggle. A match fires on the tick that brings the counter to the compare value. When A and B match on the same tick, the A action is applied.
- R6: Status bits 5, 6 and 7 are the match A, match B and overflow flags. Each interrupt output is its flag ANDed with the matching enable bit in ctrl bits 5, 6 and 7.
- R7: A flag is cleared only by a status write of 0 to that bit after a status read that returned it as 1. A write of 0 with no such read leaves the flag set.
- R8: The overflow flag sets when an increment takes the counter from 0xFF to 0x00. A clear does not set it.
- R9: Clock select 7 on channel 0 selects wide mode. Channel 1 is the low byte on its own clock, and channel 0 advances when channel 1 wraps.
- R10: In wide mode, channel 0's match flags and pin use the 16-bit values {cmp0, cmp1}, and its clear select acts on the whole counter. Only channel 0's overflow flag is set, on a 16-bit wrap.
- R11: Clock select 7 on channel 1, with channel 0 not in wide mode, increments channel 1 once for each channel 0 match A, one cycle after that match.
- R12: With status bit 4 of channel 0 set, adc_trig_o pulses high for one cycle per channel 0 match A. It stays low when the bit is clear.
- R13: addr_i[3] selects the channel. addr_i[2:0] selects ctrl (0), status (1), compare A (2), compare B (3) or count (4). Reset values are count 0, compares 0xFF, ctrl 0 and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Enables the prescaler for this cycle |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (arms flag clearing) |
| addr_i | input | 4 | Channel and register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ext_clk_i | input | 2 | External count clock per channel |
| ext_rst_i | input | 2 | External counter reset per channel |
| tmr_o | output | 2 | Timer output pin per channel |
| irq_cma_o | output | 2 | Match A interrupt per channel |
| irq_cmb_o | output | 2 | Match B interrupt per channel |
| irq_ovf_o | output | 2 | Overflow interrupt per channel |
| adc_trig_o | output | 1 | Conversion start strobe from channel 0 match A |

## Verification
The assertions assume the external clock and reset lines are slow compared with clk_i, so every level is seen through the synchroniser. They also assume a bus write to a count register is the only thing besides a tick or a hard clear that moves a counter. The stimulus holds each external level for six cycles. It writes registers only while the channel has no tick pending, so each edge, match and flag change can be traced to a single stimulus event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    CK_STOP = 3'd0, CK_DIV_A = 3'd1, CK_DIV_B = 3'd2, CK_DIV_C = 3'd3,
    CK_EXT_RISE = 3'd4, CK_EXT_FALL = 3'd5, CK_EXT_BOTH = 3'd6, CK_CHAIN = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {CLR_NONE, CLR_CMA, CLR_CMB, CLR_EXT} clr_sel_e;
  typedef enum logic [1:0] {ACT_KEEP, ACT_LOW, ACT_HIGH, ACT_TOGGLE} pin_act_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_CMPA = 3'd2;
  localparam logic [2:0] REG_CMPB = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned LOG_A = 3,
  parameter int unsigned LOG_B = 6,
  parameter int unsigned LOG_C = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_en_i,
  output logic [2:0] strb_o
);
  logic [LOG_C-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clk_en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign strb_o[0] = clk_en_i && (&cnt_q[LOG_A-1:0]);
  assign strb_o[1] = clk_en_i && (&cnt_q[LOG_B-1:0]);
  assign strb_o[2] = clk_en_i && (&cnt_q);
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ext_clk_i,
  input  logic [N-1:0] ext_rst_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rst_o
);
  logic [N-1:0] c_s0, c_s1, c_s2, r_s0, r_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_s0 <= '0; c_s1 <= '0; c_s2 <= '0; r_s0 <= '0; r_s1 <= '0;
    end else begin
      c_s0 <= ext_clk_i; c_s1 <= c_s0; c_s2 <= c_s1;
      r_s0 <= ext_rst_i; r_s1 <= r_s0;
    end
  end

  assign rise_o = c_s1 & ~c_s2;
  assign fall_o = ~c_s1 & c_s2;
  assign rst_o  = r_s1;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [2:0]    reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          clr_tick_i,
  input  logic          hard_clr_i,
  input  logic          hit_a_i,
  input  logic          hit_b_i,
  input  logic          ovf_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] nxt_o,
  output logic [DW-1:0] cmp_a_o,
  output logic [DW-1:0] cmp_b_o,
  output clk_sel_e      clk_sel_o,
  output clr_sel_e      clr_sel_o,
  output logic          trig_en_o,
  output logic [2:0]    flag_o,
  output logic [2:0]    irq_o,
  output logic          pin_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ctrl_q, cnt_q, cmp_a_q, cmp_b_q;
  logic [4:0]    cfg_q;
  logic [2:0]    flag_q, arm_q, ev;
  logic          pin_q;

  function automatic logic act(input logic [1:0] code, input logic cur);
    case (pin_act_e'(code))
      ACT_LOW:    act = 1'b0;
      ACT_HIGH:   act = 1'b1;
      ACT_TOGGLE: act = ~cur;
      default:    act = cur;
    endcase
  endfunction

  assign ev = {ovf_i, hit_b_i, hit_a_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; cfg_q <= '0; cmp_a_q <= '1; cmp_b_q <= '1;
      cnt_q <= '0; flag_q <= '0; arm_q <= '0; pin_q <= 1'b0;
    end else begin
      if (we_i && reg_i == REG_CTRL) ctrl_q  <= wdata_i;
      if (we_i && reg_i == REG_CMPA) cmp_a_q <= wdata_i;
      if (we_i && reg_i == REG_CMPB) cmp_b_q <= wdata_i;
      if (we_i && reg_i == REG_CNT)  cnt_q   <= wdata_i;
      else if (hard_clr_i)           cnt_q   <= '0;
      else if (tick_i)               cnt_q   <= nxt_o;
      if (we_i && reg_i == REG_STAT) begin
        cfg_q  <= wdata_i[4:0];
        flag_q <= (flag_q & (wdata_i[7:5] | ~arm_q)) | ev;
        arm_q  <= '0;
      end else begin
        flag_q <= flag_q | ev;
        if (re_i && reg_i == REG_STAT) arm_q <= arm_q | flag_q;
      end
      if (hit_a_i)      pin_q <= act(cfg_q[1:0], pin_q);
      else if (hit_b_i) pin_q <= act(cfg_q[3:2], pin_q);
    end
  end

  assign nxt_o     = clr_tick_i ? '0 : cnt_q + 1'b1;
  assign cnt_o     = cnt_q;
  assign cmp_a_o   = cmp_a_q;
  assign cmp_b_o   = cmp_b_q;
  assign clk_sel_o = clk_sel_e'(ctrl_q[2:0]);
  assign clr_sel_o = clr_sel_e'(ctrl_q[4:3]);
  assign trig_en_o = cfg_q[4];
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & ctrl_q[7:5];
  assign pin_o     = pin_q;

  always_comb begin
    case (reg_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_STAT: rdata_o = {flag_q, cfg_q};
      REG_CMPA: rdata_o = cmp_a_q;
      REG_CMPB: rdata_o = cmp_b_q;
      REG_CNT:  rdata_o = cnt_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned LOG_A = 3,
  parameter int unsigned LOG_B = 6,
  parameter int unsigned LOG_C = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clk_en_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [1:0]    ext_clk_i,
  input  logic [1:0]    ext_rst_i,
  output logic [1:0]    tmr_o,
  output logic [1:0]    irq_cma_o,
  output logic [1:0]    irq_cmb_o,
  output logic [1:0]    irq_ovf_o,
  output logic          adc_trig_o
);
  localparam int unsigned NCH = 2;

  logic [2:0]     strb;
  logic [NCH-1:0] rise, fall, ext_rst_s;
  logic [NCH-1:0] base_tick, tick, clr_tick, hard_clr, hit_a, hit_b, ovf, trig_en;
  logic [DW-1:0]  cnt [NCH], nxt [NCH], cmp_a [NCH], cmp_b [NCH], rdata_ch [NCH];
  logic [2:0]     flag [NCH], irq [NCH];
  clk_sel_e       clk_sel [NCH];
  clr_sel_e       clr_sel [NCH];
  logic           wide, clr16, carry1, hit_a0_q, adc_q;
  logic [DW-1:0]  nxt0_eff;
  logic [NCH-1:0] clr8;

  tmr_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_pre (
    .clk_i, .rst_ni, .clk_en_i, .strb_o(strb)
  );

  tmr_ext_sync #(.N(NCH)) u_sync (
    .clk_i, .rst_ni, .ext_clk_i, .ext_rst_i,
    .rise_o(rise), .fall_o(fall), .rst_o(ext_rst_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel u_ch (
      .clk_i, .rst_ni,
      .we_i(we_i && addr_i[3] == 1'(c)), .re_i(re_i && addr_i[3] == 1'(c)),
      .reg_i(addr_i[2:0]), .wdata_i,
      .tick_i(tick[c]), .clr_tick_i(clr_tick[c]), .hard_clr_i(hard_clr[c]),
      .hit_a_i(hit_a[c]), .hit_b_i(hit_b[c]), .ovf_i(ovf[c]),
      .cnt_o(cnt[c]), .nxt_o(nxt[c]), .cmp_a_o(cmp_a[c]), .cmp_b_o(cmp_b[c]),
      .clk_sel_o(clk_sel[c]), .clr_sel_o(clr_sel[c]), .trig_en_o(trig_en[c]),
      .flag_o(flag[c]), .irq_o(irq[c]), .pin_o(tmr_o[c]), .rdata_o(rdata_ch[c])
    );

    always_comb begin
      case (clk_sel[c])
        CK_DIV_A:    base_tick[c] = strb[0];
        CK_DIV_B:    base_tick[c] = strb[1];
        CK_DIV_C:    base_tick[c] = strb[2];
        CK_EXT_RISE: base_tick[c] = rise[c];
        CK_EXT_FALL: base_tick[c] = fall[c];
        CK_EXT_BOTH: base_tick[c] = rise[c] | fall[c];
        CK_CHAIN:    base_tick[c] = (c == 1) ? hit_a0_q && clk_sel[0] != CK_CHAIN : 1'b0;
        default:     base_tick[c] = 1'b0;
      endcase
      clr8[c] = (clr_sel[c] == CLR_CMA && cnt[c] == cmp_a[c]) ||
                (clr_sel[c] == CLR_CMB && cnt[c] == cmp_b[c]);
    end

    assign irq_cma_o[c] = irq[c][0];
    assign irq_cmb_o[c] = irq[c][1];
    assign irq_ovf_o[c] = irq[c][2];
  end

  // Channel 1 is always the low byte; channel 0 is the high byte in wide mode
  always_comb begin
    wide  = clk_sel[0] == CK_CHAIN;
    clr16 = (clr_sel[0] == CLR_CMA && {cnt[0], cnt[1]} == {cmp_a[0], cmp_a[1]}) ||
            (clr_sel[0] == CLR_CMB && {cnt[0], cnt[1]} == {cmp_b[0], cmp_b[1]});
    hard_clr[0] = ext_rst_s[0] && clr_sel[0] == CLR_EXT;
    hard_clr[1] = wide ? hard_clr[0] : ext_rst_s[1] && clr_sel[1] == CLR_EXT;
    tick[1]     = base_tick[1];
    clr_tick[1] = wide ? clr16 : clr8[1];
    carry1      = tick[1] && !clr_tick[1] && (&cnt[1]);
    tick[0]     = wide ? (carry1 || (tick[1] && clr16)) : base_tick[0];
    clr_tick[0] = wide ? clr16 : clr8[0];
    nxt0_eff    = tick[0] ? nxt[0] : cnt[0];

    hit_a[1] = tick[1] && !hard_clr[1] && nxt[1] == cmp_a[1];
    hit_b[1] = tick[1] && !hard_clr[1] && nxt[1] == cmp_b[1];
    ovf[1]   = carry1 && !hard_clr[1] && !wide;
    if (wide) begin
      hit_a[0] = tick[1] && !hard_clr[0] && {nxt0_eff, nxt[1]} == {cmp_a[0], cmp_a[1]};
      hit_b[0] = tick[1] && !hard_clr[0] && {nxt0_eff, nxt[1]} == {cmp_b[0], cmp_b[1]};
      ovf[0]   = carry1 && !hard_clr[0] && (&cnt[0]);
    end else begin
      hit_a[0] = tick[0] && !hard_clr[0] && nxt[0] == cmp_a[0];
      hit_b[0] = tick[0] && !hard_clr[0] && nxt[0] == cmp_b[0];
      ovf[0]   = tick[0] && !hard_clr[0] && !clr_tick[0] && (&cnt[0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_a0_q <= 1'b0; adc_q <= 1'b0;
    end else begin
      hit_a0_q <= hit_a[0];
      adc_q    <= hit_a[0] && trig_en[0];
    end
  end

  assign adc_trig_o = adc_q;
  assign rdata_o    = rdata_ch[addr_i[3]];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [3:0] addr_i,
  input logic [1:0] tick,
  input logic [1:0] hard_clr,
  input logic [1:0] hit_a,
  input logic [1:0] hit_b,
  input logic       wide,
  input logic [2:0] flag0,
  input logic [2:0] flag1,
  input logic [7:0] cnt0,
  input logic [7:0] cnt1,
  input logic [1:0] tmr_o,
  input logic       adc_trig_o
);
  // R4
  ext_clr0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_clr[0] && !(we_i && addr_i == 4'h4)) |=> cnt0 == 8'h00);
  // R4
  ext_clr1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_clr[1] && !(we_i && addr_i == 4'hC)) |=> cnt1 == 8'h00);
  // R3
  cnt_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt0) |-> $past(tick[0] || hard_clr[0] || we_i));
  // R5
  pin0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tmr_o[0]) |-> $past(hit_a[0] || hit_b[0]));
  // R5
  pin1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tmr_o[1]) |-> $past(hit_a[1] || hit_b[1]));
  // R6
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag0[0]) |-> $past(hit_a[0]));
  // R10
  low_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag1[2]) |-> !$past(wide));
  // R12
  adc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_trig_o |-> $past(hit_a[0]));
endmodule

bind tmr_pair tmr_pair_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .tick(tick), .hard_clr(hard_clr), .hit_a(hit_a), .hit_b(hit_b), .wide(wide),
  .flag0(flag[0]), .flag1(flag[1]), .cnt0(cnt[0]), .cnt1(cnt[1]),
  .tmr_o(tmr_o), .adc_trig_o(adc_trig_o)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  logic       clk = 1'b0, rst_ni = 1'b0, clk_en_i = 1'b0, we_i = 1'b0, re_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [1:0] ext_clk_i = '0, ext_rst_i = '0;
  logic [1:0] tmr_o, irq_cma_o, irq_cmb_o, irq_ovf_o;
  logic       adc_trig_o;
  int n_chk = 0, n_err = 0, adc_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_pair dut_i (.clk_i(clk), .rst_ni, .clk_en_i, .we_i, .re_i, .addr_i, .wdata_i,
    .rdata_o, .ext_clk_i, .ext_rst_i, .tmr_o, .irq_cma_o, .irq_cmb_o, .irq_ovf_o, .adc_trig_o);

  always @(negedge clk) if (adc_trig_o) adc_cnt++;

  // {clk3, clr2, cmpa8, cmpb8, acta2, actb2, pulses8, exp_cnt8, exp_pin1}
  localparam logic [41:0] ROWS [8] = '{
    {3'd4, 2'd0, 8'd10,  8'd200, 2'd3, 2'd0, 8'd5, 8'd5, 1'b0},  // R2 R3 free run
    {3'd4, 2'd1, 8'd3,   8'd200, 2'd3, 2'd0, 8'd6, 8'd2, 1'b1},  // R3 clear on A
    {3'd4, 2'd2, 8'd2,   8'd5,   2'd2, 2'd1, 8'd7, 8'd1, 1'b0},  // R3 R5 clear on B
    {3'd4, 2'd0, 8'd4,   8'd4,   2'd2, 2'd1, 8'd4, 8'd4, 1'b1},  // R5 A wins
    {3'd4, 2'd1, 8'd0,   8'd200, 2'd3, 2'd0, 8'd3, 8'd0, 1'b1},  // R3 period one
    {3'd6, 2'd0, 8'd255, 8'd255, 2'd0, 2'd0, 8'd3, 8'd6, 1'b0},  // R2 both edges
    {3'd5, 2'd0, 8'd255, 8'd255, 2'd0, 2'd0, 8'd3, 8'd3, 1'b0},  // R2 falling
    {3'd4, 2'd2, 8'd9,   8'd1,   2'd0, 2'd3, 8'd5, 8'd1, 1'b1}   // R5 toggle on B
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; re_i = 1'b1; #1 d = rdata_o;
    @(negedge clk); re_i = 1'b0;
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_i[ch] = 1'b1; repeat (6) @(negedge clk);
      ext_clk_i[ch] = 1'b0; repeat (6) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; ext_clk_i = '0; ext_rst_i = '0; clk_en_i = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R13 reset values
    rd(4'h4, d); check("R13 cnt reset", d, 8'h00);
    rd(4'hA, d); check("R13 cmpa reset", d, 8'hFF);
    rd(4'h1, d); check("R13 stat reset", d, 8'h00);
    check("R13 pins reset", tmr_o, 2'b00);
    wr(4'hB, 8'h5A); rd(4'hB, d); check("R13 cmpb ch1 readback", d, 8'h5A);
    rd(4'h3, d); check("R13 cmpb ch0 untouched", d, 8'hFF);

    foreach (ROWS[i]) begin
      logic [41:0] r = ROWS[i];
      do_reset();
      wr(4'h0, {3'b000, r[38:37], r[41:39]});
      wr(4'h2, r[36:29]);
      wr(4'h3, r[28:21]);
      wr(4'h1, {3'b111, 1'b0, r[18:17], r[20:19]});
      pulse(0, int'(r[16:9]));
      rd(4'h4, d);
      check($sformatf("R3 row %0d count", i), d, r[8:1]);
      check($sformatf("R5 row %0d pin", i), tmr_o[0], r[0]);
    end

    // R6 R7 flag and clear protocol
    do_reset();
    wr(4'h0, {3'b001, 2'd1, 3'd4}); wr(4'h2, 8'd3);
    pulse(0, 3);
    check("R6 irq cma", irq_cma_o[0], 1'b1);
    check("R6 irq cmb disabled", irq_cmb_o[0], 1'b0);
    wr(4'h1, 8'h00);
    check("R7 write without read keeps flag", irq_cma_o[0], 1'b1);
    rd(4'h1, d); check("R6 stat flag bit 5", d[5], 1'b1);
    wr(4'h1, 8'h00);
    check("R7 read then write clears", irq_cma_o[0], 1'b0);

    // R8 overflow
    do_reset();
    wr(4'h0, {3'b100, 2'd0, 3'd4}); wr(4'h4, 8'hFE);
    pulse(0, 1);
    check("R8 no ovf before wrap", irq_ovf_o[0], 1'b0);
    pulse(0, 1);
    rd(4'h4, d); check("R8 wrap count", d, 8'h00);
    check("R8 ovf irq", irq_ovf_o[0], 1'b1);

    // R4 external clear
    do_reset();
    wr(4'h0, {3'b000, 2'd3, 3'd4});
    pulse(0, 5);
    ext_rst_i[0] = 1'b1; repeat (5) @(negedge clk);
    rd(4'h4, d); check("R4 cleared", d, 8'h00);
    pulse(0, 2);
    rd(4'h4, d); check("R4 held clear", d, 8'h00);
    ext_rst_i[0] = 1'b0; repeat (5) @(negedge clk);
    pulse(0, 1);
    rd(4'h4, d); check("R4 resumes", d, 8'h01);

    // R1 prescaler and clock enable
    do_reset();
    wr(4'h0, 8'h01); wr(4'h8, 8'h02);
    @(negedge clk); clk_en_i = 1'b1;
    repeat (64) @(negedge clk);
    clk_en_i = 1'b0;
    rd(4'h4, d); check("R1 div8 count", d, 8'h08);
    rd(4'hC, d); check("R1 div64 count", d, 8'h01);
    repeat (50) @(negedge clk);
    rd(4'h4, d); check("R1 enable low holds", d, 8'h08);

    // R9 R10 wide mode
    do_reset();
    wr(4'h8, 8'h04); wr(4'h0, {3'b100, 2'd0, 3'd7});
    wr(4'hC, 8'hFE); wr(4'h4, 8'h12);
    pulse(1, 3);
    rd(4'h4, d); check("R9 high byte", d, 8'h13);
    rd(4'hC, d); check("R9 low byte", d, 8'h01);
    rd(4'h9, d); check("R10 low ovf flag clear", d[7], 1'b0);
    check("R10 high no ovf yet", irq_ovf_o[0], 1'b0);
    wr(4'h2, 8'h13); wr(4'hA, 8'h03);
    pulse(1, 1);
    rd(4'h1, d); check("R10 no 16-bit match at 0x1302", d[5], 1'b0);
    pulse(1, 1);
    rd(4'h1, d); check("R10 16-bit match A", d[5], 1'b1);
    wr(4'h4, 8'hFF); wr(4'hC, 8'hFF);
    pulse(1, 1);
    rd(4'h4, d); check("R9 16-bit wrap high", d, 8'h00);
    check("R10 high ovf irq", irq_ovf_o[0], 1'b1);
    rd(4'h9, d); check("R10 low ovf suppressed", d[7], 1'b0);

    // R11 R12 event mode and conversion strobe
    do_reset();
    wr(4'h0, {3'b000, 2'd1, 3'd4}); wr(4'h2, 8'd1);
    wr(4'h1, 8'hF0); wr(4'h8, 8'h07);
    adc_cnt = 0;
    pulse(0, 6);
    rd(4'hC, d); check("R11 ch1 counts ch0 matches", d, 8'h03);
    check("R12 strobe count", adc_cnt, 3);
    wr(4'h1, 8'hE0); adc_cnt = 0;
    pulse(0, 2);
    check("R12 strobe disabled", adc_cnt, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule